// File: doc/BRIEF.md
# ChaCha Keystream XOR Engine

This core produces one 64-byte ChaCha output block. A caller presents a 512-bit starting state, a 64-byte data block and an even round count, then pulses a start strobe. The core copies the state into a working register, runs the double round until the round budget is used up, adds the saved starting state back into every working word, and XORs that keystream with the captured data. The result is returned on a 512-bit output together with a one-cycle completion pulse.

A parameter selects how the double round maps onto hardware. In the iterative form, each clock applies four quarter rounds: the column group on one cycle and the diagonal group on the next. In the unrolled form, both groups are chained in one cycle. This trades adder depth for latency. A round count of zero, or an odd one, is rejected with an error pulse, and no work starts.

Top module: `chacha_xor_core`

## Requirements
- R1: Word i of `state_i`, `data_i` and `data_o` sits at bits [32i+31:32i]. Byte k of a block sits at bits [8k+7:8k], so byte 0 of the block is the low byte of word 0 (little-endian).
- R2: A quarter round on words (a,b,c,d) runs these steps in order: a+=b, d=rotl(d^a,16); c+=d, b=rotl(b^c,12); a+=b, d=rotl(d^a,8); c+=d, b=rotl(b^c,7). Every addition wraps modulo 2^32.
- R3: A double round first applies the quarter round to the columns (g, g+4, g+8, g+12) for g=0..3. It then applies it to the diagonals (g, 4+(g+1)%4, 8+(g+2)%4, 12+(g+3)%4).
- R4: After the rounds, output word i equals data word i XOR (working word i + starting state word i), modulo 2^32.
- R5: The round count is consumed two rounds per double round. `done_o` rises rounds+1 cycles after the accepting clock edge when UNROLL=0, and rounds/2+1 cycles after it when UNROLL=1.
- R6: A start in idle with a round count of zero or an odd value gives `err_o` high for exactly the next cycle. No work begins, `done_o` stays low and `data_o` keeps its value.
- R7: `start_i` is sampled only while `busy_o` is low. A start while busy has no effect on the result or the timing.
- R8: `done_o` is high for exactly one cycle. `data_o` changes only on the edge that raises `done_o` and holds until the next completion.
- R9: After reset, `busy_o`, `done_o` and `err_o` are low and `data_o` is all zeros.
- R10: `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`. It is low in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a block; sampled in idle |
| rounds_i | input | RND_W | Round count; must be even and non-zero |
| state_i | input | 512 | Starting state, sixteen 32-bit words |
| data_i | input | 512 | Data block to combine with the keystream |
| busy_o | output | 1 | Core is working on a block |
| done_o | output | 1 | One-cycle pulse: `data_o` holds a new result |
| err_o | output | 1 | One-cycle pulse: the round count was rejected |
| data_o | output | 512 | Data XOR keystream |

## Verification
The bound checker covers the control behaviour on every cycle. It checks the single-cycle `done_o` pulse, that `data_o` holds outside completion, that rejected requests raise `err_o` without `busy_o` or `done_o`, that an accepted start raises `busy_o`, and that a busy core ends only through `done_o`. The bench's independent block model covers the arithmetic content: quarter-round order, the column and diagonal index sets, the feed-forward addition and the byte placement. That model also covers the latencies of both variants, starts held across a running block, odd and zero round counts, and the shortest and longest round budgets.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_WRD = 16;
  localparam int ROW_LEN = 4;
  localparam int BLK_W   = WORD_W * NUM_WRD;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WRD-1:0] blk_t;

  function automatic word_t rotl(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, d2, b2;

  always_comb begin
    a1  = a_i + b_i;
    d1  = rotl(d_i ^ a1, 16);
    c1  = c_i + d1;
    b1  = rotl(b_i ^ c1, 12);
    a_o = a1 + b1;
    d2  = rotl(d1 ^ a_o, 8);
    c_o = c1 + d2;
    b2  = rotl(b1 ^ c_o, 7);
    d_o = d2;
    b_o = b2;
  end
endmodule

// File: rtl/chacha_half_round.sv
module chacha_half_round
  import chacha_pkg::*;
#(
  parameter int DIAG = 0
) (
  input  blk_t blk_i,
  output blk_t blk_o
);
  for (genvar g = 0; g < ROW_LEN; g++) begin : g_lane
    localparam int IA = g;
    localparam int IB = ROW_LEN     + ((g + DIAG)     % ROW_LEN);
    localparam int IC = 2 * ROW_LEN + ((g + 2 * DIAG) % ROW_LEN);
    localparam int ID = 3 * ROW_LEN + ((g + 3 * DIAG) % ROW_LEN);

    chacha_qr u_qr (
      .a_i(blk_i[IA]), .b_i(blk_i[IB]), .c_i(blk_i[IC]), .d_i(blk_i[ID]),
      .a_o(blk_o[IA]), .b_o(blk_o[IB]), .c_o(blk_o[IC]), .d_o(blk_o[ID])
    );
  end
endmodule

// File: rtl/chacha_ffxor.sv
module chacha_ffxor
  import chacha_pkg::*;
(
  input  blk_t work_i,
  input  blk_t init_i,
  input  blk_t data_i,
  output blk_t res_o
);
  for (genvar w = 0; w < NUM_WRD; w++) begin : g_word
    assign res_o[w] = data_i[w] ^ (work_i[w] + init_i[w]);
  end
endmodule

// File: rtl/chacha_xor_core.sv
module chacha_xor_core
  import chacha_pkg::*;
#(
  parameter int RND_W  = 8,
  parameter int UNROLL = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [RND_W-1:0]       rounds_i,
  input  logic [BLK_W-1:0]       state_i,
  input  logic [BLK_W-1:0]       data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [BLK_W-1:0]       data_o
);
  localparam logic [RND_W-1:0] STEP = RND_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} fsm_t;

  fsm_t             fsm;
  blk_t             work_q, init_q, dat_q;
  blk_t             col_res, dia_res, nxt_work, mix_res;
  logic [RND_W-1:0] cnt_q;
  logic             phase_q;
  logic             dr_end, last_step, bad_cnt;

  chacha_half_round #(.DIAG(0)) u_col (.blk_i(work_q), .blk_o(col_res));

  if (UNROLL != 0) begin : g_unroll
    chacha_half_round #(.DIAG(1)) u_dia (.blk_i(col_res), .blk_o(dia_res));
    assign nxt_work = dia_res;
  end else begin : g_iter
    chacha_half_round #(.DIAG(1)) u_dia (.blk_i(work_q), .blk_o(dia_res));
    assign nxt_work = phase_q ? dia_res : col_res;
  end

  chacha_ffxor u_mix (.work_i(work_q), .init_i(init_q), .data_i(dat_q), .res_o(mix_res));

  assign dr_end    = (UNROLL != 0) || phase_q;
  assign last_step = dr_end && (cnt_q == STEP);
  assign bad_cnt   = (rounds_i == '0) || rounds_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm     <= S_IDLE;
      work_q  <= '0;
      init_q  <= '0;
      dat_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (fsm)
        S_IDLE: begin
          if (start_i) begin
            if (bad_cnt) begin
              err_o <= 1'b1;
            end else begin
              work_q  <= blk_t'(state_i);
              init_q  <= blk_t'(state_i);
              dat_q   <= blk_t'(data_i);
              cnt_q   <= rounds_i;
              phase_q <= 1'b0;
              busy_o  <= 1'b1;
              fsm     <= S_RUN;
            end
          end
        end
        S_RUN: begin
          work_q  <= nxt_work;
          phase_q <= ~phase_q;
          if (dr_end) cnt_q <= cnt_q - STEP;
          if (last_step) fsm <= S_FIN;
        end
        S_FIN: begin
          data_o <= mix_res;
          done_o <= 1'b1;
          busy_o <= 1'b0;
          fsm    <= S_IDLE;
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chacha_xor_core_chk.sv
module chacha_xor_core_chk #(
  parameter int RND_W = 8,
  parameter int BW    = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [RND_W-1:0] rounds_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [BW-1:0]    data_o
);
  logic bad;
  assign bad = (rounds_i == '0) || rounds_i[0];

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(data_o));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!done_o && !busy_o));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(start_i && !busy_o && bad));

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !bad) |=> busy_o);

  p_busy_exit_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  p_idle_stay_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !(start_i && !bad)) |=> !busy_o);

  p_done_from_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

bind chacha_xor_core chacha_xor_core_chk #(.RND_W(RND_W), .BW(chacha_pkg::BLK_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .rounds_i(rounds_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .data_o(data_o)
);

// File: tb/test_chacha_xor_core.sv
module test_chacha_xor_core;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 8;
  localparam int BW = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [RW-1:0] rounds = '0;
  logic [BW-1:0] st = '0;
  logic [BW-1:0] dt = '0;

  logic          busy_w [2];
  logic          done_w [2];
  logic          err_w  [2];
  logic [BW-1:0] out_w  [2];

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;
  int wd = 0;

  int            rem  [2];
  bit            e_bsy[2];
  bit            e_dn [2];
  bit            e_er [2];
  logic [BW-1:0] e_out[2];
  logic [BW-1:0] c_st [2];
  logic [BW-1:0] c_dt [2];
  int            c_r  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  chacha_xor_core #(.RND_W(RW), .UNROLL(0)) i_chacha_xor_core (
    .clk(clk), .rst(rst), .start_i(start), .rounds_i(rounds), .state_i(st), .data_i(dt),
    .busy_o(busy_w[0]), .done_o(done_w[0]), .err_o(err_w[0]), .data_o(out_w[0]));

  chacha_xor_core #(.RND_W(RW), .UNROLL(1)) i_chacha_xor_core_unr (
    .clk(clk), .rst(rst), .start_i(start), .rounds_i(rounds), .state_i(st), .data_i(dt),
    .busy_o(busy_w[1]), .done_o(done_w[1]), .err_o(err_w[1]), .data_o(out_w[1]));

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [127:0] bqr(input logic [31:0] a, b, c, d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [BW-1:0] ref_block(input logic [BW-1:0] s, input logic [BW-1:0] d, input int r);
    logic [31:0] x [16];
    logic [127:0] q;
    logic [BW-1:0] res;
    for (int i = 0; i < 16; i++) x[i] = s[32*i +: 32];
    for (int k = 0; k < r; k++) begin
      for (int g = 0; g < 4; g++) begin
        int ia, ib, ic, id;
        int sh;
        sh = k % 2;
        ia = g;
        ib = 4 + (g + sh) % 4;
        ic = 8 + (g + 2*sh) % 4;
        id = 12 + (g + 3*sh) % 4;
        q = bqr(x[ia], x[ib], x[ic], x[id]);
        x[ia] = q[127:96]; x[ib] = q[95:64]; x[ic] = q[63:32]; x[id] = q[31:0];
      end
    end
    for (int i = 0; i < 16; i++)
      res[32*i +: 32] = d[32*i +: 32] ^ (x[i] + s[32*i +: 32]);
    return res;
  endfunction

  function automatic logic [BW-1:0] pat(input logic [31:0] seed);
    logic [BW-1:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = (seed + i) * 32'h9E3779B9 ^ {i[7:0], 24'h5A3C1F};
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural cycle model for both variants
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        rem[k] = 0; e_bsy[k] = 0; e_dn[k] = 0; e_er[k] = 0; e_out[k] = '0;
      end else begin
        e_dn[k] = 0; e_er[k] = 0;
        if (rem[k] > 0) begin
          rem[k]--;
          if (rem[k] == 0) begin
            e_dn[k] = 1; e_bsy[k] = 0;
            e_out[k] = ref_block(c_st[k], c_dt[k], c_r[k]);
          end
        end else if (start) begin
          if (rounds == 0 || rounds[0]) e_er[k] = 1;
          else begin
            c_st[k] = st; c_dt[k] = dt; c_r[k] = int'(rounds);
            rem[k] = (k == 0) ? int'(rounds) + 1 : int'(rounds) / 2 + 1;
            e_bsy[k] = 1;
          end
        end
      end
    end
    live = 1'b1;
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live && !rst) begin
      for (int k = 0; k < 2; k++) begin
        chk(busy_w[k] == e_bsy[k], "R10 busy", BW'(busy_w[k]), BW'(e_bsy[k]));
        chk(done_w[k] == e_dn[k], "R5 R8 done", BW'(done_w[k]), BW'(e_dn[k]));
        chk(err_w[k] == e_er[k], "R6 err", BW'(err_w[k]), BW'(e_er[k]));
        chk(out_w[k] === e_out[k], "R2 R3 R4 data", out_w[k], e_out[k]);
      end
    end
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      finish_run();
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (rem[0] != 0 || rem[1] != 0);
    @(negedge clk);
  endtask

  task automatic go(input logic [BW-1:0] s, input logic [BW-1:0] d, input int r);
    @(negedge clk);
    st = s; dt = d; rounds = RW'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    logic [127:0] qv;
    logic [BW-1:0] keep, exp1;
    // R2: bench quarter-round against a published vector
    qv = bqr(32'h11111111, 32'h01020304, 32'h9b8d6f43, 32'h01234567);
    chk(qv == 128'hea2a92f4_cb1cf8ce_4581472e_5881c4bb, "R2 qr vector", BW'(qv),
        BW'(128'hea2a92f4_cb1cf8ce_4581472e_5881c4bb));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    for (int k = 0; k < 2; k++)
      chk(!busy_w[k] && !done_w[k] && !err_w[k] && out_w[k] == '0, "R9 reset",
          {busy_w[k], done_w[k], err_w[k], out_w[k][0]}, '0);

    go(pat(32'd1), pat(32'd77), 20);
    go(pat(32'd2), {BW{1'b1}}, 8);
    go(pat(32'd3), '0, 2);
    // R1: byte placement with zero data
    exp1 = ref_block(pat(32'd3), '0, 2);
    for (int b = 0; b < 4; b++)
      chk(out_w[0][8*b +: 8] == exp1[8*b +: 8], "R1 byte order",
          BW'(out_w[0][8*b +: 8]), BW'(exp1[8*b +: 8]));

    // R7: starts while busy are ignored
    @(negedge clk);
    st = pat(32'd4); dt = pat(32'd5); rounds = 8'd12; start = 1'b1;
    @(negedge clk);
    st = pat(32'd9); dt = '0; rounds = 8'd4;
    repeat (5) @(negedge clk);
    start = 1'b0;
    wait_idle();
    exp1 = ref_block(pat(32'd4), pat(32'd5), 12);
    chk(out_w[0] == exp1, "R7 ignored start", out_w[0], exp1);

    // R6: invalid round counts
    keep = out_w[0];
    go(pat(32'd6), pat(32'd6), 0);
    go(pat(32'd6), pat(32'd6), 7);
    chk(out_w[0] == keep, "R6 data unchanged", out_w[0], keep);

    go(pat(32'd7), pat(32'd8), 254);

    // R8: start held through completion re-launches at once
    @(negedge clk);
    st = pat(32'd10); dt = pat(32'd11); rounds = 8'd6; start = 1'b1;
    repeat (20) @(negedge clk);
    start = 1'b0;
    wait_idle();
    exp1 = ref_block(pat(32'd10), pat(32'd11), 6);
    chk(out_w[1] == exp1, "R8 relaunch result", out_w[1], exp1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule